// File: doc/BRIEF.md
# Recirculating Serial Register Transfer Unit

This block copies the contents of a source register into a destination register one bit per clock. The two registers are wired as a single chain. The top stage of the source feeds both its own bottom stage and the bottom stage of the destination. The source therefore rotates its own data while it streams that data out, and after the full word has passed it holds the same value it started with.

The shift enable is not a user input. A small sequencer inside the block raises it when a start request arrives while the block is idle. It keeps the enable high for exactly one register width of clocks and then drops it on its own. A one-cycle done pulse marks the end of the transfer.

The source can be written in parallel only while the block is idle. A synchronous clear zeroes both registers and the sequencer, and it overrides every other input. Both registers can be read in parallel at all times.

Top module: `serxfer`

## Requirements
- R1: While `clr` is high at a clock edge, after that edge `src_q`, `dst_q`, `busy` and `done` are all zero, whatever `load_en` and `start` are doing.
- R2: When the block is idle and `load_en` is high at an edge, `src_q` equals `load_data` after that edge and `dst_q` is unchanged.
- R3: While `busy` is high, `load_en` has no effect: `src_q` keeps to the rotation sequence of R6.
- R4: When `start` is high at an edge while idle, `busy` is high from that edge for exactly W (default 8) consecutive cycles.
- R5: A `start` request made while `busy` is high is ignored, so the busy window neither lengthens nor restarts.
- R6: On each edge with `busy` high, `src_q` rotates by one toward its MSB, so bit W-1 moves to bit 0. `dst_q` shifts toward its MSB, and its bit 0 takes the old `src_q[W-1]`.
- R7: At the end of a transfer, `src_q` holds its value from before the transfer and `dst_q` holds that same value, with the same bit order.
- R8: `done` is high for exactly one cycle, the cycle in which `busy` has just fallen at the end of a full transfer. At all other times it is low.
- R9: While idle, with no load and no clear, neither register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous clear of registers and sequencer, highest priority |
| load_en | input | 1 | Parallel write of the source register, honoured only while idle |
| load_data | input | W | Parallel data for the source register |
| start | input | 1 | Request to begin a transfer, honoured only while idle |
| busy | output | 1 | Shift enable, high during the W shift cycles |
| done | output | 1 | One-cycle pulse after the last shift |
| src_q | output | W | Source register contents |
| dst_q | output | W | Destination register contents |

## Verification
The bench drives loads and start requests into the middle of running transfers. A design that did not gate them would corrupt the rotating source or stretch the busy window past W cycles. A clear issued during a transfer and a clear issued together with load and start check the priority order. A design that ranked clear lower would leave stale bits or a running sequencer behind. Every transfer is checked at its end for an intact source, and for a destination in the same bit order rather than reversed. A mistake in the feedback tap or in the shift direction shows up as a wrong final value there.

// File: rtl/serxfer_pkg.sv
package serxfer_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_SHIFT = 1'b1} xfer_state_e;
endpackage

// File: rtl/serxfer_seq.sv
module serxfer_seq import serxfer_pkg::*; #(
  parameter int W = 8,
  localparam int CW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          start,
  output logic          run,
  output logic          done,
  output logic [CW-1:0] cnt
);
  xfer_state_e st;
  logic last_shift;

  assign last_shift = (cnt == CW'(W - 1));
  assign run        = (st == ST_SHIFT);

  always_ff @(posedge clk) begin
    if (clr) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            st  <= ST_SHIFT;
            cnt <= '0;
          end
        end
        default: begin
          if (last_shift) begin
            st   <= ST_IDLE;
            cnt  <= '0;
            done <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/serxfer_ring.sv
module serxfer_ring #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         shift,
  input  logic         load,
  input  logic [W-1:0] data,
  output logic [W-1:0] q
);
  function automatic logic [W-1:0] rot_step(input logic [W-1:0] v);
    return {v[W-2:0], v[W-1]};
  endfunction

  always_ff @(posedge clk) begin
    if (clr)        q <= '0;
    else if (shift) q <= rot_step(q);
    else if (load)  q <= data;
  end
endmodule

// File: rtl/serxfer_sink.sv
module serxfer_sink #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         shift,
  input  logic         sin,
  output logic [W-1:0] q
);
  function automatic logic [W-1:0] push_step(input logic [W-1:0] v, input logic b);
    return {v[W-2:0], b};
  endfunction

  always_ff @(posedge clk) begin
    if (clr)        q <= '0;
    else if (shift) q <= push_step(q, sin);
  end
endmodule

// File: rtl/serxfer.sv
module serxfer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         load_en,
  input  logic [W-1:0] load_data,
  input  logic         start,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] src_q,
  output logic [W-1:0] dst_q
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  logic          shift_fire;
  logic          load_ok;
  logic          tap_bit;
  logic [CW-1:0] seq_cnt;

  assign load_ok = load_en & ~shift_fire;
  assign tap_bit = src_q[W-1];
  assign busy    = shift_fire;

  serxfer_seq #(.W(W)) u_seq (
    .clk(clk), .clr(clr), .start(start),
    .run(shift_fire), .done(done), .cnt(seq_cnt)
  );

  serxfer_ring #(.W(W)) u_src (
    .clk(clk), .clr(clr), .shift(shift_fire),
    .load(load_ok), .data(load_data), .q(src_q)
  );

  serxfer_sink #(.W(W)) u_dst (
    .clk(clk), .clr(clr), .shift(shift_fire),
    .sin(tap_bit), .q(dst_q)
  );
endmodule

// File: rtl/serxfer_chk.sv
module serxfer_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         clr,
  input logic         load_en,
  input logic [W-1:0] load_data,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] src_q,
  input logic [W-1:0] dst_q
);
  localparam int LW = $clog2(W + 2) + 1;
  logic [LW-1:0] run_len;
  logic          seen;

  always_ff @(posedge clk) begin
    seen <= 1'b1;
    if (clr)       run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  assert_clear_R1: assert property (@(posedge clk)
    clr |=> (src_q == '0 && dst_q == '0 && !busy && !done));

  assert_load_R2: assert property (@(posedge clk) disable iff (clr)
    (seen && !busy && load_en) |=> (src_q == $past(load_data) && $stable(dst_q)));

  assert_start_R4: assert property (@(posedge clk) disable iff (clr)
    (seen && !busy && start) |=> busy);

  assert_window_R5: assert property (@(posedge clk) disable iff (clr)
    (seen && $fell(busy) && !$past(clr)) |-> (run_len == LW'(W)));

  assert_rotate_R6: assert property (@(posedge clk) disable iff (clr)
    (seen && busy) |=> (src_q == {$past(src_q[W-2:0]), $past(src_q[W-1])}
                        && dst_q == {$past(dst_q[W-2:0]), $past(src_q[W-1])}));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (clr)
    (seen && done) |-> ($fell(busy) && !$past(done)));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (clr)
    (seen && !busy && !load_en) |=> ($stable(src_q) && $stable(dst_q)));
endmodule

bind serxfer serxfer_chk #(.W(W)) u_chk (
  .clk(clk), .clr(clr), .load_en(load_en), .load_data(load_data),
  .start(start), .busy(busy), .done(done), .src_q(src_q), .dst_q(dst_q)
);

// File: tb/serxfer_test.sv
module serxfer_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         clr = 1'b1;
  logic         load_en = 1'b0;
  logic [W-1:0] load_data = '0;
  logic         start = 1'b0;
  logic         busy, done;
  logic [W-1:0] src_q, dst_q;

  int total = 0;
  int bad = 0;

  logic [W-1:0] ma = '0, mb = '0;
  logic         mrun = 1'b0, mdone = 1'b0;
  int           mcnt = 0;

  always #2 clk = ~clk;

  serxfer #(.W(W)) uut (
    .clk(clk), .clr(clr), .load_en(load_en), .load_data(load_data),
    .start(start), .busy(busy), .done(done), .src_q(src_q), .dst_q(dst_q)
  );

  function automatic logic [W-1:0] rotl1(input logic [W-1:0] v);
    return (v << 1) | W'(v >> (W - 1));
  endfunction

  function automatic logic [W-1:0] pushin(input logic [W-1:0] v, input logic b);
    return (v << 1) | W'(b);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic c, input logic l, input logic [W-1:0] d, input logic s);
    string rtag;
    @(negedge clk);
    clr = c; load_en = l; load_data = d; start = s;
    @(posedge clk);
    if (c) begin
      rtag = "R1";
      ma = '0; mb = '0; mrun = 1'b0; mcnt = 0; mdone = 1'b0;
    end else begin
      mdone = 1'b0;
      if (mrun) begin
        rtag = (l ? "R3" : "R6");
        mb = pushin(mb, ma[W-1]);
        ma = rotl1(ma);
        if (mcnt == W - 1) begin mrun = 1'b0; mdone = 1'b1; mcnt = 0; end
        else mcnt++;
      end else begin
        rtag = (l ? "R2" : "R9");
        if (l) ma = d;
        if (s) begin mrun = 1'b1; mcnt = 0; end
      end
    end
    #1;
    check(src_q == ma, {rtag, " src_q"}, 32'(src_q), 32'(ma));
    check(dst_q == mb, {rtag, " dst_q"}, 32'(dst_q), 32'(mb));
    check(busy == mrun, (c ? "R1 busy" : "R4 busy"), 32'(busy), 32'(mrun));
    check(done == mdone, "R8 done", 32'(done), 32'(mdone));
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=hang expected=finish");
    finish_run();
  end

  initial begin
    int blen;
    void'($urandom(32'd2718));
    // R1: reset state and clear beating load and start
    cyc(1'b1, 1'b0, '0, 1'b0);
    cyc(1'b1, 1'b1, 8'hFF, 1'b1);
    check(src_q == 0 && dst_q == 0 && !busy && !done, "R1 clear priority", 32'(src_q), 32'h0);

    // R2 load while idle
    cyc(1'b0, 1'b1, 8'hB4, 1'b0);
    check(src_q == 8'hB4, "R2 load", 32'(src_q), 32'hB4);

    // R4 start, R3 load during run, R5 restart during run
    cyc(1'b0, 1'b0, '0, 1'b1);
    blen = 1;
    for (int i = 0; i < W + 3; i++) begin
      cyc(1'b0, (i == 2), 8'h11, (i == 4));
      if (busy) blen++;
    end
    check(blen == W, "R5 busy window", 32'(blen), 32'(W));
    // R7 both hold the original word
    check(src_q == 8'hB4, "R7 source kept", 32'(src_q), 32'hB4);
    check(dst_q == 8'hB4, "R7 destination copy", 32'(dst_q), 32'hB4);

    // R9 idle hold
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, 8'h5A, 1'b0);
    check(src_q == 8'hB4 && dst_q == 8'hB4, "R9 idle hold", 32'(dst_q), 32'hB4);

    // R1 clear mid transfer
    cyc(1'b0, 1'b1, 8'h81, 1'b1);
    cyc(1'b0, 1'b0, '0, 1'b0);
    cyc(1'b0, 1'b0, '0, 1'b0);
    cyc(1'b1, 1'b0, '0, 1'b0);
    check(!busy && src_q == 0 && dst_q == 0, "R1 mid clear", 32'(busy), 32'h0);

    // R7 second pattern with asymmetric bits
    cyc(1'b0, 1'b1, 8'h01, 1'b1);
    for (int i = 0; i < W + 1; i++) cyc(1'b0, 1'b0, '0, 1'b0);
    check(dst_q == 8'h01 && src_q == 8'h01, "R7 bit order", 32'(dst_q), 32'h01);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      cyc(($urandom % 97) == 0, ($urandom % 4) == 0, W'($urandom), ($urandom % 6) == 0);
    end
    finish_run();
  end
endmodule